// File: doc/BRIEF.md
# DSP Register File with Address Side Effects

This block holds the 32 sixteen-bit registers of a small signal-processing core and carries out two register-move instructions on them. One is a plain move between any two registers. The other is a short load that puts a sign-extended 8-bit constant into one of the eight auxiliary and accumulator registers. Several addresses do more than store a value.

Four addresses are windows onto private 8-entry stacks. A write to a window pushes and a read from a window pops. The two accumulator high registers keep only a sign-extended low byte. A write to an accumulator middle register can also fill the rest of that accumulator, depending on a mode bit in the status register.

An instruction is taken on any clock edge where its strobe is high, and it finishes in that cycle. A separate debug port reads any register combinationally, and that read never pops a stack.

Top module: `dsp_regfile_se`

## Requirements
- R1: After synchronous reset every register, every stack entry and every stack pointer is zero.
- R2: A valid word with `(word & 0xFC00) == 0x1C00` is a move. It copies the register addressed by bits 4:0 into the register addressed by bits 9:5 in one clock. The other rules below apply on top of this.
- R3: A valid word with `(word & 0xF800) == 0x0800` is a short load. It writes bits 7:0, sign-extended to 16 bits, into register 0x18 plus bits 10:8.
- R4: A write to 0x10 or 0x11 (accumulator high, units 0 and 1) stores bits 7:0 of the value, sign-extended to 16 bits.
- R5: Addresses 0x0C to 0x0F are windows onto stacks 0 to 3, each 8 deep with a 3-bit wrapping pointer. A write to a window first advances that stack's pointer by one. It then saves the window's old visible value in the slot at the new pointer, and finally shows the written value in the window.
- R6: A move whose source is a window returns the visible value. The window then takes the slot at the current pointer, and the pointer steps back by one, wrapping.
- R7: When both source and destination of a move are windows, the pop of the source happens before the push of the destination. This holds even when both are the same window.
- R8: While bit 14 of the status register 0x13 is set, a move or short load into 0x1E or 0x1F (accumulator middle, units 0 and 1) also does two things. It sets the matching high register (0x10 or 0x11) to 0xFFFF if bit 15 of the value is 1, and to 0x0000 if it is 0. It also clears the matching low register (0x1C or 0x1D).
- R9: While status bit 14 is clear, a write to 0x1E or 0x1F changes only that register.
- R10: A cycle with the strobe low, or a word that is neither a move nor a short load, changes no register, stack entry or pointer.
- R11: The debug port returns the addressed register in the same cycle, and a window returns its visible value. A debug read does not pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction strobe |
| ins_word | input | 16 | Instruction word |
| dbg_addr | input | 5 | Debug read address |
| dbg_data | output | 16 | Debug read data, combinational |

## Verification
The bench builds the block with its default parameters: 16-bit registers, 32 addresses, and four stacks 8 deep. With only eight slots per stack, a short run of pushes already wraps a pointer past the mask. This lets the directed pushes and the random moves reach the overwrite-on-wrap case as well as the stack-to-stack ordering. The random stream writes the status register often, so accumulator-middle writes land in both modes.

// File: rtl/rfx_pkg.sv
package rfx_pkg;
    localparam int RF_DW     = 16;
    localparam int RF_AW     = 5;
    localparam int RF_NREG   = 32;
    localparam int STK_N     = 4;
    localparam int STK_DEPTH = 8;

    localparam int RA_WIN0 = 12;
    localparam int RA_ACH0 = 16;
    localparam int RA_ACH1 = 17;
    localparam int RA_STAT = 19;
    localparam int RA_AXL0 = 24;
    localparam int RA_ACL0 = 28;
    localparam int RA_ACL1 = 29;
    localparam int RA_ACM0 = 30;
    localparam int RA_ACM1 = 31;
    localparam int MODE_BIT = 14;

    typedef struct packed {
        logic                mv;
        logic                ld;
        logic [RF_AW-1:0]    src;
        logic [RF_AW-1:0]    dst;
        logic [RF_DW-1:0]    imm;
    } op_t;

    function automatic logic [RF_DW-1:0] sext8(input logic [7:0] b);
        return {{(RF_DW-8){b[7]}}, b};
    endfunction

    function automatic logic is_win(input logic [RF_AW-1:0] a);
        return (a >= RF_AW'(RA_WIN0)) && (a < RF_AW'(RA_WIN0 + STK_N));
    endfunction
endpackage

// File: rtl/rfx_decode.sv
module rfx_decode
    import rfx_pkg::*;
(
    input  logic              valid,
    input  logic [15:0]       word,
    output op_t               op
);
    always_comb begin
        op     = '0;
        op.src = word[4:0];
        op.imm = sext8(word[7:0]);
        if (valid && word[15:10] == 6'b000111) begin
            op.mv  = 1'b1;
            op.dst = word[9:5];
        end else if (valid && word[15:11] == 5'b00001) begin
            op.ld  = 1'b1;
            op.dst = {2'b11, word[10:8]};
        end else begin
            op.dst = word[9:5];
        end
    end
endmodule

// File: rtl/rfx_stack.sv
module rfx_stack #(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      pop,
    input  logic                      push,
    input  logic [DW-1:0]             push_val,
    output logic [DW-1:0]             vis_o,
    output logic [$clog2(DEPTH)-1:0]  ptr_o
);
    localparam int PW = $clog2(DEPTH);

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] vis_q;
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ptr_mid, ptr_up;
    logic [DW-1:0] top_mid;

    // pop (if any) resolves first, push then builds on the popped state
    always_comb begin
        ptr_mid = pop ? ptr_q - PW'(1) : ptr_q;
        top_mid = pop ? mem_q[ptr_q] : vis_q;
        ptr_up  = ptr_mid + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            vis_q <= '0;
            ptr_q <= '0;
        end else if (push) begin
            mem_q[ptr_up] <= top_mid;
            ptr_q         <= ptr_up;
            vis_q         <= push_val;
        end else if (pop) begin
            ptr_q <= ptr_mid;
            vis_q <= top_mid;
        end
    end

    assign vis_o = vis_q;
    assign ptr_o = ptr_q;
endmodule

// File: rtl/rfx_bank.sv
module rfx_bank
    import rfx_pkg::*;
#(
    parameter int DW   = RF_DW,
    parameter int AW   = RF_AW,
    parameter int NREG = RF_NREG,
    parameter int NWIN = STK_N
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [AW-1:0]        wa,
    input  logic [DW-1:0]        wd,
    input  logic [NWIN*DW-1:0]   win_vals,
    output logic [NREG*DW-1:0]   view_o
);
    logic          mode40;
    logic          ext;
    logic [AW-1:0] hi_idx, lo_idx;

    assign mode40 = view_o[RA_STAT*DW + MODE_BIT];
    assign ext    = we && mode40 &&
                    (wa == AW'(RA_ACM0) || wa == AW'(RA_ACM1));
    assign hi_idx = (wa == AW'(RA_ACM0)) ? AW'(RA_ACH0) : AW'(RA_ACH1);
    assign lo_idx = (wa == AW'(RA_ACM0)) ? AW'(RA_ACL0) : AW'(RA_ACL1);

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        if (g >= RA_WIN0 && g < RA_WIN0 + NWIN) begin : g_win
            assign view_o[g*DW +: DW] = win_vals[(g-RA_WIN0)*DW +: DW];
        end else begin : g_reg
            localparam bit IS_HI = (g == RA_ACH0) || (g == RA_ACH1);
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (ext && hi_idx == AW'(g)) begin
                    q <= {DW{wd[DW-1]}};
                end else if (ext && lo_idx == AW'(g)) begin
                    q <= '0;
                end else if (we && wa == AW'(g)) begin
                    q <= IS_HI ? sext8(wd[7:0]) : wd;
                end
            end
            assign view_o[g*DW +: DW] = q;
        end
    end
endmodule

// File: rtl/dsp_regfile_se.sv
module dsp_regfile_se
    import rfx_pkg::*;
#(
    parameter int DW    = RF_DW,
    parameter int AW    = RF_AW,
    parameter int NREG  = RF_NREG,
    parameter int NSTK  = STK_N,
    parameter int DEPTH = STK_DEPTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ins_valid,
    input  logic [15:0]   ins_word,
    input  logic [AW-1:0] dbg_addr,
    output logic [DW-1:0] dbg_data
);
    localparam int PW = $clog2(DEPTH);

    op_t                 op;
    logic                wr;
    logic [DW-1:0]       wval;
    logic [NREG*DW-1:0]  view_flat;
    logic [NSTK*DW-1:0]  win_flat;
    logic [NSTK*PW-1:0]  ptr_flat;

    rfx_decode u_dec (
        .valid (ins_valid),
        .word  (ins_word),
        .op    (op)
    );

    assign wr   = op.mv | op.ld;
    assign wval = op.ld ? op.imm : view_flat[op.src*DW +: DW];

    for (genvar n = 0; n < NSTK; n++) begin : g_stk
        logic pop_n, push_n;
        assign pop_n  = op.mv && op.src == AW'(RA_WIN0 + n);
        assign push_n = wr && op.dst == AW'(RA_WIN0 + n);
        rfx_stack #(.DW(DW), .DEPTH(DEPTH)) u_stk (
            .clk      (clk),
            .rst      (rst),
            .pop      (pop_n),
            .push     (push_n),
            .push_val (wval),
            .vis_o    (win_flat[n*DW +: DW]),
            .ptr_o    (ptr_flat[n*PW +: PW])
        );
    end

    rfx_bank #(.DW(DW), .AW(AW), .NREG(NREG), .NWIN(NSTK)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .we       (wr && !is_win(op.dst)),
        .wa       (op.dst),
        .wd       (wval),
        .win_vals (win_flat),
        .view_o   (view_flat)
    );

    assign dbg_data = view_flat[dbg_addr*DW +: DW];
endmodule

// File: rtl/dsp_regfile_se_chk.sv
module dsp_regfile_se_chk
    import rfx_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     ins_valid,
    input logic [15:0]              ins_word,
    input logic [RF_NREG*RF_DW-1:0] view_flat,
    input logic [STK_N*3-1:0]       ptr_flat
);
    logic        is_mv, is_ld;
    logic [15:0] src_val;
    logic [2:0]  ptr0;
    logic [15:0] st0, ach0, acl0, acm0;
    logic        mode_on, to_acm0;

    assign is_mv   = ins_valid && ins_word[15:10] == 6'b000111;
    assign is_ld   = ins_valid && ins_word[15:11] == 5'b00001;
    assign src_val = view_flat[ins_word[4:0]*16 +: 16];
    assign ptr0    = ptr_flat[2:0];
    assign st0     = view_flat[RA_WIN0*16 +: 16];
    assign ach0    = view_flat[RA_ACH0*16 +: 16];
    assign acl0    = view_flat[RA_ACL0*16 +: 16];
    assign acm0    = view_flat[RA_ACM0*16 +: 16];
    assign mode_on = view_flat[RA_STAT*16 + MODE_BIT];
    assign to_acm0 = (is_mv && ins_word[9:5] == 5'd30) ||
                     (is_ld && ins_word[10:8] == 3'd6);

    // R4
    ach_sext_chk: assert property (@(posedge clk) disable iff (rst)
        ach0[15:8] == {8{ach0[7]}});

    // R5
    push_chk: assert property (@(posedge clk) disable iff (rst)
        (is_mv && ins_word[9:5] == 5'd12 && ins_word[4:2] != 3'b011)
        |=> (ptr0 == $past(ptr0) + 3'd1) && (st0 == $past(src_val)));

    // R6
    pop_chk: assert property (@(posedge clk) disable iff (rst)
        (is_mv && ins_word[4:0] == 5'd12 && ins_word[9:7] != 3'b011)
        |=> ptr0 == $past(ptr0) - 3'd1);

    // R8
    mode_on_chk: assert property (@(posedge clk) disable iff (rst)
        (to_acm0 && mode_on) |=> (acl0 == 16'h0) && (ach0 == {16{acm0[15]}}));

    // R9
    mode_off_chk: assert property (@(posedge clk) disable iff (rst)
        (to_acm0 && !mode_on) |=> $stable(ach0) && $stable(acl0));

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !ins_valid |=> $stable(view_flat) && $stable(ptr_flat));
endmodule

bind dsp_regfile_se dsp_regfile_se_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ins_valid (ins_valid),
    .ins_word  (ins_word),
    .view_flat (view_flat),
    .ptr_flat  (ptr_flat)
);

// File: tb/dsp_regfile_se_test.sv
`timescale 1ns/100ps
module dsp_regfile_se_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid = 1'b0;
    logic [15:0] ins_word = '0;
    logic [4:0]  dbg_addr = '0;
    logic [15:0] dbg_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [15:0] mreg [32];
    logic [15:0] mstk [4][8];
    logic [2:0]  mptr [4];

    always #2.5 clk = ~clk;

    dsp_regfile_se uut (
        .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_word(ins_word),
        .dbg_addr(dbg_addr), .dbg_data(dbg_data)
    );

    function automatic logic [15:0] mv_w(input int d, input int s);
        return 16'h1C00 | 16'((d & 31) << 5) | 16'(s & 31);
    endfunction
    function automatic logic [15:0] ld_w(input int d, input int imm);
        return 16'h0800 | 16'((d & 7) << 8) | 16'(imm & 255);
    endfunction
    function automatic logic [15:0] sx(input logic [7:0] b);
        return {{8{b[7]}}, b};
    endfunction

    task automatic m_write(input int d, input logic [15:0] v);
        if (d >= 12 && d <= 15) begin
            mptr[d-12] = mptr[d-12] + 3'd1;
            mstk[d-12][mptr[d-12]] = mreg[d];
            mreg[d] = v;
        end else if (d == 16 || d == 17) begin
            mreg[d] = sx(v[7:0]);
        end else begin
            mreg[d] = v;
            if ((d == 30 || d == 31) && mreg[19][14]) begin
                mreg[d-14] = {16{v[15]}};
                mreg[d-2]  = 16'h0;
            end
        end
    endtask

    task automatic m_exec(input logic [15:0] w);
        if ((w & 16'hFC00) == 16'h1C00) begin
            int s = int'(w[4:0]);
            logic [15:0] v = mreg[s];
            if (s >= 12 && s <= 15) begin
                mreg[s] = mstk[s-12][mptr[s-12]];
                mptr[s-12] = mptr[s-12] - 3'd1;
            end
            m_write(int'(w[9:5]), v);
        end else if ((w & 16'hF800) == 16'h0800) begin
            m_write(24 + int'(w[10:8]), sx(w[7:0]));
        end
    endtask

    task automatic run(input logic [15:0] w);
        @(negedge clk);
        ins_valid = 1'b1;
        ins_word  = w;
        @(negedge clk);
        ins_valid = 1'b0;
        m_exec(w);
    endtask

    task automatic chk_lit(input string tag, input int a, input logic [15:0] exp);
        dbg_addr = 5'(a);
        #0.1;
        n_chk++;
        if (dbg_data !== exp) begin
            n_bad++;
            $display("FAIL %s reg 0x%02h actual=%04h expected=%04h", tag, a, dbg_data, exp);
        end
    endtask

    task automatic chk_m(input string tag, input int a);
        chk_lit(tag, a, mreg[a]);
    endtask

    task automatic chk_all(input string tag);
        for (int a = 0; a < 32; a++) chk_m(tag, a);
    endtask

    initial begin
        for (int a = 0; a < 32; a++) mreg[a] = '0;
        for (int n = 0; n < 4; n++) begin
            mptr[n] = '0;
            for (int k = 0; k < 8; k++) mstk[n][k] = '0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset contents
        for (int a = 0; a < 32; a++) chk_lit("R1", a, 16'h0);

        // R3: short load sign extension
        run(ld_w(0, 8'h80)); chk_lit("R3", 24, 16'hFF80);
        run(ld_w(1, 8'h7F)); chk_lit("R3", 25, 16'h007F);
        // R4: accumulator high keeps sign-extended low byte
        run(mv_w(16, 24)); chk_lit("R4", 16, 16'hFF80);
        run(mv_w(17, 25)); chk_lit("R4", 17, 16'h007F);
        // R2: plain move
        run(ld_w(2, 8'h3C)); run(mv_w(5, 26)); chk_lit("R2", 5, 16'h003C);

        // R5: push two values into window 0
        run(mv_w(12, 24)); run(mv_w(12, 25));
        chk_lit("R5", 12, 16'h007F);
        // R11: debug reads do not pop
        chk_lit("R11", 12, 16'h007F);
        chk_lit("R11", 12, 16'h007F);
        // R6: pops come back in reverse order
        run(mv_w(5, 12)); chk_lit("R6", 5, 16'h007F); chk_lit("R6", 12, 16'hFF80);
        run(mv_w(6, 12)); chk_lit("R6", 6, 16'hFF80); chk_lit("R6", 12, 16'h0000);

        // R5: wrap past eight entries on window 1
        for (int i = 1; i <= 10; i++) begin
            run(ld_w(0, i)); run(mv_w(13, 24));
        end
        chk_lit("R5", 13, 16'h000A);
        for (int i = 0; i < 10; i++) begin
            run(mv_w(7, 13)); chk_m("R6", 7); chk_m("R5", 13);
        end

        // R7: window to window
        run(ld_w(0, 8'h42)); run(mv_w(14, 24));
        run(mv_w(15, 14));
        chk_lit("R7", 15, 16'h0042); chk_lit("R7", 14, 16'h0000);
        run(mv_w(15, 15)); chk_lit("R7", 15, 16'h0042);
        run(mv_w(7, 15)); chk_lit("R7", 7, 16'h0042); chk_lit("R7", 15, 16'h0000);

        // R8: 40-bit mode on
        run(ld_w(0, 8'h80)); run(mv_w(19, 24));
        run(ld_w(4, 8'h11)); run(ld_w(5, 8'h22));
        run(ld_w(6, 8'h90));
        chk_lit("R8", 30, 16'hFF90); chk_lit("R8", 16, 16'hFFFF); chk_lit("R8", 28, 16'h0000);
        run(ld_w(7, 8'h05));
        chk_lit("R8", 31, 16'h0005); chk_lit("R8", 17, 16'h0000); chk_lit("R8", 29, 16'h0000);
        run(ld_w(4, 8'h11)); run(mv_w(30, 25));
        chk_lit("R8", 30, 16'h007F); chk_lit("R8", 16, 16'h0000); chk_lit("R8", 28, 16'h0000);

        // R9: mode off
        run(ld_w(1, 8'h05)); run(mv_w(19, 25));
        run(ld_w(4, 8'h33)); run(mv_w(16, 24));
        run(ld_w(6, 8'h81));
        chk_lit("R9", 30, 16'hFF81); chk_lit("R9", 16, 16'hFF80); chk_lit("R9", 28, 16'h0033);

        // R10: ignored words and idle strobe
        run(16'h1BFF); run(16'h1000); run(16'hF8FF);
        chk_all("R10");
        @(negedge clk);
        ins_word = mv_w(5, 24);
        @(negedge clk);
        chk_lit("R10", 5, mreg[5]);

        // R2: constrained random mix against the model
        void'($urandom(32'd1234));
        for (int it = 0; it < 400; it++) begin
            int r = int'($urandom % 10);
            logic [15:0] w;
            if (r < 5)      w = mv_w(int'($urandom % 32), int'($urandom % 32));
            else if (r < 8) w = ld_w(int'($urandom % 8), int'($urandom % 256));
            else            w = 16'($urandom);
            run(w);
            chk_all("R2");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule